// File: doc/BRIEF.md
# PLL Bring-up and Shutdown Sequencer

This block drives the control word of one on-chip PLL through a fixed register-level order. On an enable request it programs the multiplier and divider factors with the PLL powered and bypassed. It then pulses the PLL's reset and polls the lock indication, writing a clear-slip strobe on every poll that finds the PLL unlocked. Once every lock bit is high it leaves bypass and sets the output enable in a single write. On a disable request it bypasses the PLL first and only then removes power and enable together.

When the instance feeds the processor clock (the main PLL), the sequencer also owns the system clock selector. It moves the processor to the base input before touching the PLL and returns it to the PLL only after the output is enabled. A lock wait that runs longer than a parameterised number of cycles sets an error flag and abandons the sequence, leaving the PLL bypassed. Requests that arrive during a sequence are held and served afterwards. The block also reports the effective output ratio as a numerator and a denominator.

Top module: `pll_seq_top`

## Requirements
- R1: After reset the control word is all zeros, sysSel is 0 (base input), busy and lockErr are 0, and the ratio reads 0/1.
- R2: An enable writes the control word with R in bits 3:0, F in bits 9:4, OD in bits 13:10, bandwidth in bits 19:14, reset in bit 20, power in bit 21, bypass in bit 23 and enable in bit 25. When HAS_SRC is set, bits 27:26 carry srcSel; otherwise they stay 0.
- R3: On the main PLL, sysSel falls to 0 before power and factors are written, and it returns to 1 only after the enable bit is set with bypass clear.
- R4: After the factor write, the reset bit is driven low, then high for exactly RST_HOLD cycles, then low, before the lock wait begins.
- R5: During the lock wait, the lock field is lockStat[LOCK_SHIFT +: LOCK_WIDTH], and the PLL counts as locked only when every bit of that field is 1. Each unlocked cycle produces a one-cycle pulse on clrSlip bit LOCK_SHIFT+2 only; other lockStat bits are ignored.
- R6: Once locked, bypass clears and enable sets on the same cycle.
- R7: A disable sets bypass one cycle before power and enable both clear, and those two clear on the same cycle.
- R8: An enable request while the PLL is already running (reset 0, power 1, enable 1) leaves the control word unchanged and still gives one done pulse.
- R9: busy is high in every cycle of a sequence. done is a one-cycle pulse at the end of each completed sequence. A request arriving while busy is served after the current sequence.
- R10: If the lock wait lasts LOCK_TIMEOUT cycles, lockErr sets. The sequencer then goes idle with bypass 1, enable 0, sysSel 0 and no done pulse. The next enable clears lockErr.
- R11: The ratio reads 1/1 when bypass is set, 0/1 when power is clear, and otherwise (F+1)/((R+1)*(OD+1)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enReq | input | 1 | Enable request pulse |
| disReq | input | 1 | Disable request pulse |
| facR | input | 4 | Reference divider factor |
| facF | input | 6 | Feedback multiplier factor |
| facOd | input | 4 | Output divider factor |
| facBw | input | 6 | Bandwidth adjust factor |
| srcSel | input | 2 | Reference source select (used when HAS_SRC) |
| lockStat | input | LOCK_BUS_W | Shared lock status bus from the PLL |
| ctrlWord | output | 32 | PLL control word |
| clrSlip | output | LOCK_BUS_W | Clear-slip strobe onto the shared lock bus |
| sysSel | output | 1 | System clock select: 0 base input, 1 PLL |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed (one cycle) |
| lockErr | output | 1 | Lock wait timed out |
| ratioNum | output | 7 | Output ratio numerator |
| ratioDen | output | 9 | Output ratio denominator |

## Verification
The properties assume that the PLL model raises lock only while reset is low and power is high. They also assume that a request is a one-cycle pulse, so a single request never starts two sequences. The stimulus pulses each request for one cycle from a falling clock edge. The model drops the lock field whenever reset is high or power is low, and it shows a partially set field one cycle before full lock, which exercises the all-bits rule. A stuck mode keeps the field low to reach the timeout path.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int R_W  = 4;
  localparam int F_W  = 6;
  localparam int OD_W = 4;
  localparam int BW_W = 6;
  localparam int F_LO  = R_W;
  localparam int OD_LO = F_LO + F_W;
  localparam int BW_LO = OD_LO + OD_W;
  localparam int FAC_W = BW_LO + BW_W;
  localparam int NUM_W = F_W + 1;
  localparam int DEN_W = R_W + OD_W + 1;
  localparam int BIT_RST = 20;
  localparam int BIT_PWR = 21;
  localparam int BIT_BYP = 23;
  localparam int BIT_EN  = 25;
  localparam int SRC_LO  = 26;
  localparam int CW_W    = 32;

  typedef struct packed {
    logic parkSys;
    logic unparkSys;
    logic loadFactors;
    logic rstLow;
    logic rstHigh;
    logic runEnable;
    logic setBypass;
    logic powerDown;
    logic slipPulse;
    logic errSet;
    logic errClr;
  } seq_strobe_t;
endpackage

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter bit IS_MAIN      = 1'b1,
  parameter int LOCK_TIMEOUT = 256,
  parameter int RST_HOLD     = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enReq,
  input  logic        disReq,
  input  logic        locked,
  input  logic        running,
  output seq_strobe_t stb,
  output logic        busy,
  output logic        done
);
  localparam int CNT_MAX = (LOCK_TIMEOUT > RST_HOLD) ? LOCK_TIMEOUT : RST_HOLD;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PARK, S_PROG, S_RLO, S_RHI, S_RREL, S_LWAIT,
    S_RUN, S_UNPARK, S_BYP, S_PDN, S_FIN
  } state_t;

  state_t state, nextState;
  logic [CNT_W-1:0] cnt;
  logic enPend, disPend, enAll, disAll, takeEn, takeDis;

  always_comb begin
    enAll   = enPend | enReq;
    disAll  = disPend | disReq;
    takeDis = (state == S_IDLE) && disAll;
    takeEn  = (state == S_IDLE) && !disAll && enAll;
    nextState = state;
    stb = '0;
    unique case (state)
      S_IDLE: begin
        if (takeDis) nextState = S_BYP;
        else if (takeEn) begin
          if (running) nextState = S_FIN;
          else nextState = IS_MAIN ? S_PARK : S_PROG;
        end
      end
      S_PARK:  begin stb.parkSys = 1'b1; nextState = S_PROG; end
      S_PROG:  begin stb.loadFactors = 1'b1; stb.errClr = 1'b1; nextState = S_RLO; end
      S_RLO:   begin stb.rstLow = 1'b1; nextState = S_RHI; end
      S_RHI: begin
        stb.rstHigh = 1'b1;
        if (cnt == CNT_W'(RST_HOLD - 1)) nextState = S_RREL;
      end
      S_RREL:  begin stb.rstLow = 1'b1; nextState = S_LWAIT; end
      S_LWAIT: begin
        if (locked) nextState = S_RUN;
        else begin
          stb.slipPulse = 1'b1;
          if (cnt == CNT_W'(LOCK_TIMEOUT - 1)) begin
            stb.errSet = 1'b1;
            nextState = S_IDLE;
          end
        end
      end
      S_RUN:    begin stb.runEnable = 1'b1; nextState = IS_MAIN ? S_UNPARK : S_FIN; end
      S_UNPARK: begin stb.unparkSys = 1'b1; nextState = S_FIN; end
      S_BYP:    begin stb.setBypass = 1'b1; nextState = S_PDN; end
      S_PDN:    begin stb.powerDown = 1'b1; nextState = S_FIN; end
      S_FIN:    nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      enPend  <= 1'b0;
      disPend <= 1'b0;
    end else begin
      state   <= nextState;
      enPend  <= enAll & ~takeEn;
      disPend <= disAll & ~takeDis;
      if (nextState != state || (state != S_RHI && state != S_LWAIT)) cnt <= '0;
      else cnt <= cnt + 1'b1;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);
endmodule

// File: rtl/pll_seq_dp.sv
module pll_seq_dp
  import pll_seq_pkg::*;
#(
  parameter int LOCK_BUS_W = 12,
  parameter int LOCK_SHIFT = 0,
  parameter int LOCK_WIDTH = 2,
  parameter bit HAS_SRC    = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seq_strobe_t           stb,
  input  logic [R_W-1:0]        facR,
  input  logic [F_W-1:0]        facF,
  input  logic [OD_W-1:0]       facOd,
  input  logic [BW_W-1:0]       facBw,
  input  logic [1:0]            srcSel,
  input  logic [LOCK_BUS_W-1:0] lockStat,
  output logic [CW_W-1:0]       ctrlWord,
  output logic [LOCK_BUS_W-1:0] clrSlip,
  output logic                  sysSel,
  output logic                  lockErr,
  output logic                  locked,
  output logic                  running,
  output logic [NUM_W-1:0]      ratioNum,
  output logic [DEN_W-1:0]      ratioDen
);
  localparam int SLIP_POS = LOCK_SHIFT + 2;
  localparam logic [LOCK_BUS_W-1:0] SLIP_ONE = LOCK_BUS_W'(1) << SLIP_POS;

  logic [1:0] srcBits;
  generate
    if (HAS_SRC) begin : g_src
      assign srcBits = srcSel;
    end else begin : g_nosrc
      assign srcBits = 2'b00;
    end
  endgenerate

  assign locked  = &lockStat[LOCK_SHIFT +: LOCK_WIDTH];
  assign running = !ctrlWord[BIT_RST] && ctrlWord[BIT_PWR] && ctrlWord[BIT_EN];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord <= '0;
      sysSel   <= 1'b0;
      lockErr  <= 1'b0;
      clrSlip  <= '0;
    end else begin
      if (stb.parkSys)   sysSel <= 1'b0;
      if (stb.unparkSys) sysSel <= 1'b1;
      if (stb.loadFactors) begin
        ctrlWord[FAC_W-1:0]      <= {facBw, facOd, facF, facR};
        ctrlWord[BIT_PWR]        <= 1'b1;
        ctrlWord[BIT_BYP]        <= 1'b1;
        ctrlWord[SRC_LO +: 2]    <= srcBits;
      end
      if (stb.rstHigh) ctrlWord[BIT_RST] <= 1'b1;
      if (stb.rstLow)  ctrlWord[BIT_RST] <= 1'b0;
      if (stb.runEnable) begin
        ctrlWord[BIT_BYP] <= 1'b0;
        ctrlWord[BIT_EN]  <= 1'b1;
      end
      if (stb.setBypass) ctrlWord[BIT_BYP] <= 1'b1;
      if (stb.powerDown) begin
        ctrlWord[BIT_PWR] <= 1'b0;
        ctrlWord[BIT_EN]  <= 1'b0;
      end
      if (stb.errSet) lockErr <= 1'b1;
      else if (stb.errClr) lockErr <= 1'b0;
      clrSlip <= stb.slipPulse ? SLIP_ONE : '0;
    end
  end

  always_comb begin
    if (ctrlWord[BIT_BYP]) begin
      ratioNum = NUM_W'(1);
      ratioDen = DEN_W'(1);
    end else if (!ctrlWord[BIT_PWR]) begin
      ratioNum = '0;
      ratioDen = DEN_W'(1);
    end else begin
      ratioNum = NUM_W'(ctrlWord[F_LO +: F_W]) + NUM_W'(1);
      ratioDen = (DEN_W'(ctrlWord[0 +: R_W]) + DEN_W'(1)) *
                 (DEN_W'(ctrlWord[OD_LO +: OD_W]) + DEN_W'(1));
    end
  end
endmodule

// File: rtl/pll_seq_top.sv
module pll_seq_top
  import pll_seq_pkg::*;
#(
  parameter bit IS_MAIN      = 1'b1,
  parameter bit HAS_SRC      = 1'b0,
  parameter int LOCK_BUS_W   = 12,
  parameter int LOCK_SHIFT   = 0,
  parameter int LOCK_WIDTH   = 2,
  parameter int LOCK_TIMEOUT = 256,
  parameter int RST_HOLD     = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enReq,
  input  logic                  disReq,
  input  logic [3:0]            facR,
  input  logic [5:0]            facF,
  input  logic [3:0]            facOd,
  input  logic [5:0]            facBw,
  input  logic [1:0]            srcSel,
  input  logic [LOCK_BUS_W-1:0] lockStat,
  output logic [31:0]           ctrlWord,
  output logic [LOCK_BUS_W-1:0] clrSlip,
  output logic                  sysSel,
  output logic                  busy,
  output logic                  done,
  output logic                  lockErr,
  output logic [6:0]            ratioNum,
  output logic [8:0]            ratioDen
);
  seq_strobe_t stb;
  logic locked, running;

  pll_seq_ctrl #(
    .IS_MAIN(IS_MAIN), .LOCK_TIMEOUT(LOCK_TIMEOUT), .RST_HOLD(RST_HOLD)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .enReq(enReq), .disReq(disReq),
    .locked(locked), .running(running), .stb(stb), .busy(busy), .done(done)
  );

  pll_seq_dp #(
    .LOCK_BUS_W(LOCK_BUS_W), .LOCK_SHIFT(LOCK_SHIFT),
    .LOCK_WIDTH(LOCK_WIDTH), .HAS_SRC(HAS_SRC)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .facR(facR), .facF(facF),
    .facOd(facOd), .facBw(facBw), .srcSel(srcSel), .lockStat(lockStat),
    .ctrlWord(ctrlWord), .clrSlip(clrSlip), .sysSel(sysSel),
    .lockErr(lockErr), .locked(locked), .running(running),
    .ratioNum(ratioNum), .ratioDen(ratioDen)
  );
endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk
  import pll_seq_pkg::*;
#(
  parameter bit IS_MAIN    = 1'b1,
  parameter int LOCK_BUS_W = 12,
  parameter int LOCK_SHIFT = 0
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [31:0]           ctrlWord,
  input logic [LOCK_BUS_W-1:0] clrSlip,
  input logic                  sysSel,
  input logic                  busy,
  input logic                  done,
  input logic [6:0]            ratioNum,
  input logic [8:0]            ratioDen
);
  localparam logic [LOCK_BUS_W-1:0] SLIP_ONE = LOCK_BUS_W'(1) << (LOCK_SHIFT + 2);

  // R6
  run_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlWord[BIT_EN]) |-> $fell(ctrlWord[BIT_BYP]));
  // R7
  power_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlWord[BIT_PWR]) |-> (ctrlWord[BIT_BYP] && $past(ctrlWord[BIT_BYP]) && !ctrlWord[BIT_EN]));
  // R5
  slip_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrSlip & ~SLIP_ONE) == '0);
  // R4
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlWord[BIT_RST]) |-> $past(ctrlWord[BIT_RST], 2));
  // R3
  unpark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (IS_MAIN && $rose(sysSel)) |-> (ctrlWord[BIT_EN] && !ctrlWord[BIT_BYP]));
  // R3
  park_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (IS_MAIN && $rose(ctrlWord[BIT_PWR])) |-> !sysSel);
  // R9
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  // R11
  bypass_ratio_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWord[BIT_BYP] |-> (ratioNum == 7'd1 && ratioDen == 9'd1));
endmodule

bind pll_seq_top pll_seq_chk #(
  .IS_MAIN(IS_MAIN), .LOCK_BUS_W(LOCK_BUS_W), .LOCK_SHIFT(LOCK_SHIFT)
) uChk (
  .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .clrSlip(clrSlip),
  .sysSel(sysSel), .busy(busy), .done(done),
  .ratioNum(ratioNum), .ratioDen(ratioDen)
);

// File: tb/sim_pll_seq_top.sv
module sim_pll_seq_top;
  localparam int BUS_W = 8;
  localparam int SHIFT = 3;
  localparam int TMO   = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enReq = 1'b0, disReq = 1'b0;
  logic [3:0] facR = '0, facOd = '0;
  logic [5:0] facF = '0, facBw = '0;
  logic [1:0] srcSel = 2'b10;
  logic [BUS_W-1:0] lockStat;
  logic [31:0] ctrlWord;
  logic [BUS_W-1:0] clrSlip;
  logic sysSel, busy, done, lockErr;
  logic [6:0] ratioNum;
  logic [8:0] ratioDen;

  always #5 clk = ~clk;

  pll_seq_top #(
    .IS_MAIN(1'b1), .HAS_SRC(1'b1), .LOCK_BUS_W(BUS_W), .LOCK_SHIFT(SHIFT),
    .LOCK_WIDTH(2), .LOCK_TIMEOUT(TMO), .RST_HOLD(2)
  ) u0 (
    .clk(clk), .rstN(rstN), .enReq(enReq), .disReq(disReq), .facR(facR),
    .facF(facF), .facOd(facOd), .facBw(facBw), .srcSel(srcSel),
    .lockStat(lockStat), .ctrlWord(ctrlWord), .clrSlip(clrSlip),
    .sysSel(sysSel), .busy(busy), .done(done), .lockErr(lockErr),
    .ratioNum(ratioNum), .ratioDen(ratioDen)
  );

  // PLL model: lock field rises lockDelay cycles after reset falls with power on
  int lockDelay = 3;
  bit stuck = 1'b0;
  int lockCnt = 0;
  logic [1:0] lockField;
  always @(posedge clk) begin
    if (ctrlWord[20] || !ctrlWord[21]) lockCnt <= 0;
    else if (lockCnt < 1000) lockCnt <= lockCnt + 1;
  end
  always_comb begin
    lockField = 2'b00;
    if (!stuck && ctrlWord[21] && !ctrlWord[20]) begin
      if (lockCnt >= lockDelay) lockField = 2'b11;
      else if (lockCnt == lockDelay - 1 && lockDelay > 1) lockField = 2'b01;
    end
    lockStat = {3'b000, lockField, 2'b00, 1'b1};
  end

  // event log sampled at falling edges
  int cyc = 0;
  int tSelFall, tSelRise, tPwrRise, tPwrFall, tRstRise, tRstFall;
  int tEnRise, tEnFall, tBypRise, tBypFall;
  int slipCnt, badSlip, doneCnt;
  logic [31:0] pCw = '0;
  logic pSel = 1'b0;

  task automatic clearLog();
    tSelFall = -1; tSelRise = -1; tPwrRise = -1; tPwrFall = -1;
    tRstRise = -1; tRstFall = -1; tEnRise = -1; tEnFall = -1;
    tBypRise = -1; tBypFall = -1;
    slipCnt = 0; badSlip = 0; doneCnt = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (pSel && !sysSel && tSelFall < 0) tSelFall = cyc;
      if (!pSel && sysSel && tSelRise < 0) tSelRise = cyc;
      if (!pCw[21] && ctrlWord[21] && tPwrRise < 0) tPwrRise = cyc;
      if (pCw[21] && !ctrlWord[21] && tPwrFall < 0) tPwrFall = cyc;
      if (!pCw[20] && ctrlWord[20] && tRstRise < 0) tRstRise = cyc;
      if (pCw[20] && !ctrlWord[20] && tRstFall < 0) tRstFall = cyc;
      if (!pCw[25] && ctrlWord[25] && tEnRise < 0) tEnRise = cyc;
      if (pCw[25] && !ctrlWord[25] && tEnFall < 0) tEnFall = cyc;
      if (!pCw[23] && ctrlWord[23]) tBypRise = cyc;
      if (pCw[23] && !ctrlWord[23] && tBypFall < 0) tBypFall = cyc;
      if (clrSlip == 8'b0010_0000) slipCnt++;
      else if (clrSlip != '0) badSlip++;
      if (done) doneCnt++;
    end
    pCw = ctrlWord;
    pSel = sysSel;
  end

  int nChk = 0, nFail = 0;
  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulseEn();
    @(negedge clk) enReq = 1'b1;
    @(negedge clk) enReq = 1'b0;
  endtask
  task automatic pulseDis();
    @(negedge clk) disReq = 1'b1;
    @(negedge clk) disReq = 1'b0;
  endtask
  task automatic waitIdle();
    int quiet = 0;
    while (quiet < 3) begin
      @(negedge clk);
      if (!busy) quiet++; else quiet = 0;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin : main
    clearLog();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ctrlWord == 32'h0, "R1", "ctrlWord", int'(ctrlWord), 0);
    chk(!sysSel && !busy && !lockErr, "R1", "sel/busy/err", {sysSel, busy, lockErr}, 0);
    chk(ratioNum == 0 && ratioDen == 1, "R1", "ratio num", int'(ratioNum), 0);
    rstN = 1'b1;

    // first enable, lock after 3 cycles
    facR = 4'd1; facF = 6'd59; facOd = 4'd3; facBw = 6'd59; lockDelay = 3;
    clearLog();
    pulseEn();
    chk(busy, "R9", "busy after request", busy, 1);
    waitIdle();
    chk(ctrlWord[19:0] == {6'd59, 4'd3, 6'd59, 4'd1}, "R2", "factor fields",
        int'(ctrlWord[19:0]), int'({6'd59, 4'd3, 6'd59, 4'd1}));
    chk(ctrlWord[21] && ctrlWord[25] && !ctrlWord[23] && !ctrlWord[20], "R2", "pwr/en/byp/rst",
        int'(ctrlWord[25:20]), 6'b100010);
    chk(ctrlWord[27:26] == 2'b10, "R2", "source bits", int'(ctrlWord[27:26]), 2);
    chk(ratioNum == 60 && ratioDen == 8, "R11", "ratio num*1000+den",
        int'(ratioNum) * 1000 + int'(ratioDen), 60008);
    chk(sysSel, "R3", "sysSel back on PLL", sysSel, 1);
    chk(slipCnt == 3, "R5", "slip pulses", slipCnt, 3);
    chk(badSlip == 0, "R5", "misplaced slip pulses", badSlip, 0);
    chk(tRstFall - tRstRise == 2, "R4", "reset high cycles", tRstFall - tRstRise, 2);
    chk(tRstRise > tPwrRise && tPwrRise > 0, "R4", "reset after factor write", tRstRise, tPwrRise + 2);
    chk(tEnRise == tBypFall && tEnRise > 0, "R6", "enable vs bypass cycle", tEnRise, tBypFall);
    chk(doneCnt == 1, "R9", "done pulses", doneCnt, 1);

    // R8 enable while running
    begin
      logic [31:0] cw0;
      cw0 = ctrlWord;
      clearLog();
      pulseEn();
      waitIdle();
      chk(ctrlWord == cw0, "R8", "ctrlWord unchanged", int'(ctrlWord), int'(cw0));
      chk(doneCnt == 1 && slipCnt == 0, "R8", "done pulses", doneCnt, 1);
    end

    // R7 disable ordering
    clearLog();
    pulseDis();
    waitIdle();
    chk(tBypRise > 0 && tPwrFall == tBypRise + 1, "R7", "power-down cycle", tPwrFall, tBypRise + 1);
    chk(tEnFall == tPwrFall, "R7", "enable falls with power", tEnFall, tPwrFall);
    chk(ratioNum == 1 && ratioDen == 1, "R11", "bypass ratio num", int'(ratioNum), 1);

    // R3 parking order on re-enable, R5 longer lock
    lockDelay = 7;
    clearLog();
    pulseEn();
    waitIdle();
    chk(tSelFall > 0 && tSelFall < tPwrRise, "R3", "park before power", tSelFall, tPwrRise - 1);
    chk(tSelRise > tEnRise && tEnRise > 0, "R3", "unpark after enable", tSelRise, tEnRise + 1);
    chk(slipCnt == 7, "R5", "slip pulses delay 7", slipCnt, 7);

    // R9 request queued behind a running sequence
    lockDelay = 1;
    clearLog();
    pulseDis();
    pulseEn();
    waitIdle();
    chk(doneCnt == 2, "R9", "queued sequences done", doneCnt, 2);
    chk(ctrlWord[21] && ctrlWord[25] && !ctrlWord[23], "R9", "running after queue",
        int'(ctrlWord[25:21]), 5'b10001);

    // R10 lock timeout
    pulseDis();
    waitIdle();
    stuck = 1'b1;
    clearLog();
    pulseEn();
    waitIdle();
    chk(lockErr, "R10", "error flag", lockErr, 1);
    chk(ctrlWord[23] && !ctrlWord[25], "R10", "bypass kept, enable low",
        int'({ctrlWord[25], ctrlWord[23]}), 1);
    chk(!sysSel, "R10", "sysSel parked", sysSel, 0);
    chk(slipCnt == TMO, "R10", "polls before timeout", slipCnt, TMO);
    chk(doneCnt == 0, "R10", "no done pulse", doneCnt, 0);
    stuck = 1'b0;
    clearLog();
    pulseEn();
    waitIdle();
    chk(!lockErr && ctrlWord[25], "R10", "error cleared on retry", lockErr, 0);

    // R11 sweep over divider and multiplier factors
    for (int r = 0; r < 16; r++) begin
      for (int od = 0; od < 16; od++) begin
        for (int fi = 0; fi < 4; fi++) begin
          int f;
          f = (fi == 0) ? 0 : (fi == 1) ? 22 : (fi == 2) ? 59 : 63;
          pulseDis();
          waitIdle();
          facR = 4'(r); facOd = 4'(od); facF = 6'(f); facBw = 6'(f);
          pulseEn();
          waitIdle();
          chk(ratioNum == 7'(f + 1) && ratioDen == 9'((r + 1) * (od + 1)), "R11",
              "ratio num*1000+den", int'(ratioNum) * 1000 + int'(ratioDen),
              (f + 1) * 1000 + (r + 1) * (od + 1));
          chk(ctrlWord[19:0] == {6'(f), 4'(od), 6'(f), 4'(r)}, "R2", "swept fields",
              int'(ctrlWord[19:0]), int'({6'(f), 4'(od), 6'(f), 4'(r)}));
        end
      end
    end

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule